// File: doc/BRIEF.md
# Far-Bank Call Stack Sequencer

This block sits beside a processor core that reaches more than 64 KiB of code through a code-bank byte. It holds the 16-bit program counter, the code-bank register, the 8-bit stack pointer and a status byte. On command it steps through the stack writes and reads for a far call, a far return, interrupt entry and interrupt return, with one stack access per clock on a byte-wide memory port. The core's decoder supplies the operation, the target bank and address (or the interrupt vector), and the status byte to save. It watches `busy` and `done` to know when the control-flow change has finished.

The bank byte is saved for calls and far returns only when bit 15 of the program counter is set, which marks a banked code region. Interrupt entry and interrupt return always save and restore the bank byte. A separate combinational path builds 24-bit data addresses. Accesses to the lower 32 KiB pass through unbanked. Accesses at 0x8000 and above take their top byte from a data-bank byte, which the surrounding system reads from RAM location 0xFF.

Top module: `farbank_stack_seq`

## Requirements
- R1: After reset: pc = 0xC000 (parameter RESET_PC), code_bank = 0, sp = 0xFF, stat_out = 0, busy = 0 and done = 0.
- R2: Every stack access is at address 0x0100 + stack byte, one access per clock. A push writes at 0x0100+sp and then decrements sp. A pop increments sp and then reads at the new 0x0100+sp. sp wraps modulo 256 in both directions.
- R3: Far call (cmd_op = 0) with pc bit 15 set pushes code_bank, then pc[15:8], then pc[7:0]. In the cycle after the last push, pc takes opd_addr and code_bank takes opd_bank together.
- R4: Far call with pc bit 15 clear pushes only pc[15:8] and then pc[7:0]; no bank byte is stacked.
- R5: Far return (cmd_op = 1) pops the PC low byte and then the PC high byte. It pops one more byte into code_bank only when the restored pc has bit 15 set; otherwise code_bank is unchanged.
- R6: Interrupt entry (cmd_op = 2) pushes code_bank, pc[15:8], pc[7:0] and then stat_in. It then loads pc from opd_addr, clears code_bank to 0, and sets stat_out to stat_in with the interrupt-disable bit (bit 2) forced to 1.
- R7: Interrupt return (cmd_op = 3) pops the status into stat_out with bits 4 and 5 forced to 1. It then pops the PC low byte, the PC high byte and the bank byte.
- R8: busy is high from the clock after a command is accepted until the sequence ends. done is high for exactly one cycle, the cycle of the final stack access.
- R9: A command presented while busy is high is ignored: it starts no access and changes no state.
- R10: dat_addr_out = {0x00, dat_addr_in} when dat_addr_in < 0x8000, and {dat_bank, dat_addr_in} otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 0 far call, 1 far return, 2 interrupt entry, 3 interrupt return |
| opd_bank | input | 8 | Target code bank for a far call |
| opd_addr | input | 16 | Call target or interrupt vector |
| stat_in | input | 8 | Status byte stacked on interrupt entry |
| stat_out | output | 8 | Status register |
| pc | output | 16 | Program counter |
| code_bank | output | 8 | Current code bank |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final access cycle of a sequence |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Stack write enable |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, combinational from mem_addr |
| dat_addr_in | input | 16 | Data access address from the core |
| dat_bank | input | 8 | Data-bank byte (the RAM byte at 0xFF) |
| dat_addr_out | output | 24 | Formed 24-bit data address |

## Verification
The far call is driven once from a banked PC and once from an unbanked PC. This shows whether the conditional bank push follows bit 15 and not the operation alone. Far returns then unwind to both kinds of PC, so the optional bank pop is seen both taken and skipped. The skipped case also shows that the bank stays intact. Interrupt entry and return are driven 64 levels deep, enough for the stack pointer to wrap past zero both ways. In one of them a second command is held high while busy, to show that overlapping requests are dropped. Data addresses on both sides of 0x8000 show where banking starts.

// File: rtl/farbank_stack_seq.sv
module farbank_stack_seq #(
  parameter logic [15:0] RESET_PC   = 16'hC000,
  parameter logic [7:0]  RESET_SP   = 8'hFF,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter int          I_BIT      = 2,
  parameter int          B_BIT      = 4,
  parameter int          E_BIT      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  opd_bank,
  input  logic [15:0] opd_addr,
  input  logic [7:0]  stat_in,
  output logic [7:0]  stat_out,
  output logic [15:0] pc,
  output logic [7:0]  code_bank,
  output logic [7:0]  sp,
  output logic        busy,
  output logic        done,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic [15:0] dat_addr_in,
  input  logic [7:0]  dat_bank,
  output logic [23:0] dat_addr_out
);
  localparam logic [1:0] OP_CALL = 2'd0;
  localparam logic [1:0] OP_RET  = 2'd1;
  localparam logic [1:0] OP_IENT = 2'd2;
  localparam logic [1:0] OP_IRET = 2'd3;
  localparam logic [7:0] I_MASK  = 8'(1 << I_BIT);
  localparam logic [7:0] BE_MASK = 8'((1 << B_BIT) | (1 << E_BIT));

  logic        active;
  logic [1:0]  op_q, step_q, phase;
  logic [7:0]  tgt_bank_q, stat_q, lo_q, sp_inc;
  logic [15:0] tgt_pc_q;
  logic        is_push, last;

  assign is_push  = ~op_q[0];
  assign sp_inc   = sp + 8'd1;
  assign phase    = (op_q == OP_RET) ? step_q + 2'd1 : step_q;
  assign busy     = active;
  assign done     = active & last;
  assign mem_we   = active & is_push;
  assign mem_addr = {STACK_PAGE, is_push ? sp : sp_inc};
  assign dat_addr_out = dat_addr_in[15] ? {dat_bank, dat_addr_in} : {8'h00, dat_addr_in};

  always_comb begin
    case (step_q)
      2'd0:    mem_wdata = code_bank;
      2'd1:    mem_wdata = pc[15:8];
      2'd2:    mem_wdata = pc[7:0];
      default: mem_wdata = stat_q;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_CALL: last = (step_q == 2'd2);
      OP_IENT: last = (step_q == 2'd3);
      OP_RET:  last = (phase == 2'd3) | ((phase == 2'd2) & ~mem_rdata[7]);
      default: last = (phase == 2'd3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      op_q       <= OP_CALL;
      step_q     <= 2'd0;
      tgt_bank_q <= 8'h00;
      tgt_pc_q   <= 16'h0000;
      stat_q     <= 8'h00;
      lo_q       <= 8'h00;
      pc         <= RESET_PC;
      code_bank  <= 8'h00;
      sp         <= RESET_SP;
      stat_out   <= 8'h00;
    end else if (!active) begin
      if (cmd_valid) begin
        active     <= 1'b1;
        op_q       <= cmd_op;
        tgt_bank_q <= opd_bank;
        tgt_pc_q   <= opd_addr;
        stat_q     <= stat_in;
        step_q     <= (cmd_op == OP_CALL && !pc[15]) ? 2'd1 : 2'd0;
      end
    end else begin
      step_q <= step_q + 2'd1;
      if (last) active <= 1'b0;
      if (is_push) begin
        sp <= sp - 8'd1;
        if (last) begin
          pc        <= tgt_pc_q;
          code_bank <= (op_q == OP_IENT) ? 8'h00 : tgt_bank_q;
          if (op_q == OP_IENT) stat_out <= stat_q | I_MASK;
        end
      end else begin
        sp <= sp_inc;
        case (phase)
          2'd0:    stat_out  <= mem_rdata | BE_MASK;
          2'd1:    lo_q      <= mem_rdata;
          2'd2:    pc        <= {mem_rdata, lo_q};
          default: code_bank <= mem_rdata;
        endcase
      end
    end
  end

  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_push) |=> sp == $past(sp) - 8'd1);
  assert_pop_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !is_push) |=> sp == $past(sp) + 8'd1);
  assert_stack_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_addr[15:8] == STACK_PAGE);
  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_ient_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_IENT) |=> (code_bank == 8'h00) && stat_out[I_BIT]);
  assert_iret_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_IRET) |=> stat_out[B_BIT] && stat_out[E_BIT]);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> $stable(sp) && $stable(pc) && $stable(code_bank));
endmodule

// File: tb/farbank_stack_seq_tb.sv
module farbank_stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  opd_bank = 8'h00, stat_in = 8'h00, dat_bank = 8'h00;
  logic [15:0] opd_addr = 16'h0000, dat_addr_in = 16'h0000;
  logic [7:0]  stat_out, code_bank, sp, mem_wdata, mem_rdata;
  logic [15:0] pc, mem_addr;
  logic        busy, done, mem_we;
  logic [23:0] dat_addr_out;

  logic [7:0]  smem [256];
  logic [7:0]  ref_mem [256];
  logic [15:0] m_pc;
  logic [7:0]  m_bank, m_sp, m_stat;
  logic        q_we [$];
  logic [15:0] q_addr [$];
  logic [7:0]  q_dat [$];
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  farbank_stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .opd_bank(opd_bank), .opd_addr(opd_addr), .stat_in(stat_in),
    .stat_out(stat_out), .pc(pc), .code_bank(code_bank), .sp(sp),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dat_addr_in(dat_addr_in),
    .dat_bank(dat_bank), .dat_addr_out(dat_addr_out));

  assign mem_rdata = smem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d expected below 100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mpush(input logic [7:0] v);
    q_we.push_back(1'b1); q_addr.push_back({8'h01, m_sp}); q_dat.push_back(v);
    ref_mem[m_sp] = v;
    m_sp = m_sp - 8'd1;
  endtask

  task automatic mpop(output logic [7:0] v);
    m_sp = m_sp + 8'd1;
    q_we.push_back(1'b0); q_addr.push_back({8'h01, m_sp}); q_dat.push_back(8'h00);
    v = ref_mem[m_sp];
  endtask

  task automatic run_cmd(input string tag, input logic [1:0] op, input logic [7:0] bnk,
                         input logic [15:0] adr, input logic [7:0] st, input bit poke);
    logic [7:0] lo, hi, b;
    case (op)
      2'd0: begin
        if (m_pc[15]) mpush(m_bank);
        mpush(m_pc[15:8]); mpush(m_pc[7:0]);
        m_pc = adr; m_bank = bnk;
      end
      2'd1: begin
        mpop(lo); mpop(hi); m_pc = {hi, lo};
        if (m_pc[15]) begin mpop(b); m_bank = b; end
      end
      2'd2: begin
        mpush(m_bank); mpush(m_pc[15:8]); mpush(m_pc[7:0]); mpush(st);
        m_pc = adr; m_bank = 8'h00; m_stat = st | 8'h04;
      end
      default: begin
        mpop(b); m_stat = b | 8'h30;
        mpop(lo); mpop(hi); m_pc = {hi, lo};
        mpop(b); m_bank = b;
      end
    endcase
    cmd_valid = 1'b1; cmd_op = op; opd_bank = bnk; opd_addr = adr; stat_in = st;
    @(posedge clk); @(negedge clk);
    cmd_valid = poke; cmd_op = ~op; opd_bank = 8'h5A; opd_addr = 16'h1234; stat_in = 8'hEE;
    while (q_we.size() > 0) begin
      chk({"R8 busy ", tag}, busy, 1'b1);
      chk({"R8 done ", tag}, done, q_we.size() == 1);
      chk({"R2 we ", tag}, mem_we, q_we[0]);
      chk({"R2 addr ", tag}, mem_addr, q_addr[0]);
      if (q_we[0]) chk({"wdata ", tag}, mem_wdata, q_dat[0]);
      if (q_we.size() == 1) cmd_valid = 1'b0;
      void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_dat.pop_front());
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk({"R8 idle ", tag}, busy, 1'b0);
    chk({"R8 nodone ", tag}, done, 1'b0);
    chk({"pc ", tag}, pc, m_pc);
    chk({"bank ", tag}, code_bank, m_bank);
    chk({"R2 sp ", tag}, sp, m_sp);
    chk({"stat ", tag}, stat_out, m_stat);
  endtask

  task automatic chk_dat(input logic [15:0] a, input logic [7:0] b, input logic [23:0] exp);
    dat_addr_in = a; dat_bank = b; #1;
    chk("R10 data address", dat_addr_out, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin smem[i] = 8'h00; ref_mem[i] = 8'h00; end
    m_pc = 16'hC000; m_bank = 8'h00; m_sp = 8'hFF; m_stat = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 16'hC000);
    chk("R1 bank", code_bank, 8'h00);
    chk("R1 sp", sp, 8'hFF);
    chk("R1 stat", stat_out, 8'h00);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_dat(16'h0000, 8'h77, 24'h000000);
    chk_dat(16'h7FFF, 8'h77, 24'h007FFF);
    chk_dat(16'h8000, 8'h77, 24'h778000);
    chk_dat(16'hFFFF, 8'hA5, 24'hA5FFFF);
    chk_dat(16'h1234, 8'hFF, 24'h001234);
    run_cmd("R3 far call banked", 2'd0, 8'h12, 16'h4321, 8'h00, 1'b0);
    run_cmd("R4 far call unbanked", 2'd0, 8'h34, 16'h9ABC, 8'h00, 1'b0);
    run_cmd("R6 irq entry", 2'd2, 8'h00, 16'hFFE0, 8'h81, 1'b0);
    run_cmd("R7 irq return", 2'd3, 8'h00, 16'h0000, 8'h00, 1'b0);
    run_cmd("R5 far return unbanked", 2'd1, 8'h00, 16'h0000, 8'h00, 1'b0);
    run_cmd("R5 far return banked", 2'd1, 8'h00, 16'h0000, 8'h00, 1'b0);
    run_cmd("R9 busy ignore call", 2'd0, 8'h56, 16'hD000, 8'h00, 1'b1);
    for (int i = 0; i < 64; i++)
      run_cmd(i == 5 ? "R9 busy ignore nest" : "R2 wrap nest", 2'd2, 8'h00,
              16'h8000 | 16'(i), 8'(i), i == 5);
    for (int i = 0; i < 64; i++)
      run_cmd(i == 7 ? "R9 busy ignore unnest" : "R2 wrap unnest", 2'd3, 8'h00,
              16'h0000, 8'h00, i == 7);
    run_cmd("R5 far return after wrap", 2'd1, 8'h00, 16'h0000, 8'h00, 1'b0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule